// File: doc/BRIEF.md
# Transmit Frame Gate

The block sits between a transmit buffer and a byte-wide transmit path. Software places a complete wire image in the buffer: seven 0x55 preamble bytes, a 0xD5 start delimiter, the frame body and a four-byte check sequence. It then writes the total byte count to the count register. A nonzero write starts one transmit attempt.

The attempt first checks the count against a lower and an upper limit. It then reads buffer bytes 0 to 7 and checks that they form the preamble and delimiter. If both checks pass, the block streams the body, which is every byte between the delimiter and the check sequence, and clears the count register. Whether the attempt passes or fails, it ends with a one-cycle done interrupt. A failed attempt leaves the written count in the register, so software can tell the frame was refused.

The buffer is read through a synchronous port with one cycle of latency. The output stream has no backpressure: it is a byte, a valid strobe and a last flag.

Top module: `tx_frame_gate`

## Requirements
- R1: Out of reset, cnt_o is 0, and tx_valid_o, tx_last_o, irq_o and buf_rd_en_o are all 0.
- R2: While idle, a count write stores cnt_wdata_i in cnt_o. A nonzero value starts an attempt. A zero value starts nothing: no buffer read, no output byte and no interrupt.
- R3: A count below 64 is refused. No output byte is produced, irq_o pulses, and cnt_o keeps the written value.
- R4: A count above 1530 is refused with the same outcome as R3.
- R5: The header is buffer bytes 0 to 6 equal to 0x55 and byte 7 equal to 0xD5. A count within limits whose header differs in any of these eight bytes is refused with the same outcome as R3.
- R6: An accepted attempt emits count minus 12 bytes on tx_data_o. The bytes are buffer bytes from address 8 upward, in address order, one per cycle, with no gap.
- R7: tx_last_o is high with the final emitted byte of an accepted attempt and at no other time.
- R8: After an accepted attempt, cnt_o reads 0 no later than the cycle in which irq_o is high.
- R9: Every attempt produces exactly one irq_o pulse, one cycle wide.
- R10: A count write is ignored while an attempt is in progress, from the cycle after the starting write up to and including the irq_o cycle. cnt_o is unchanged and no second attempt follows.
- R11: Buffer data is taken one cycle after buf_rd_en_o with buf_addr_o. Header reads use addresses 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_wr_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | CNT_W | Count value to write |
| cnt_o | output | CNT_W | Count register contents |
| buf_rd_en_o | output | 1 | Buffer read enable |
| buf_addr_o | output | ADDR_W | Buffer byte address |
| buf_rdata_i | input | 8 | Buffer read data, one cycle after the read |
| tx_data_o | output | 8 | Output byte |
| tx_valid_o | output | 1 | Output byte valid |
| tx_last_o | output | 1 | Final byte of the frame |
| irq_o | output | 1 | One-cycle done pulse per attempt |

## Verification
Two events can fall in the same cycle: the end of an attempt, where the count is cleared and irq_o fires, and a new software write to the count register. The bench watches for the interrupt cycle and drives a write in that exact cycle, after both an accepted and a refused attempt. It then expects cnt_o to stay at 0 or at the refused value, and expects no second interrupt and no further buffer reads. A second write is also driven in the middle of a stream; the bench expects the original byte count to be emitted in full.

// File: rtl/tx_gate_pkg.sv
package tx_gate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HDR,
    ST_HDR_END,
    ST_STREAM,
    ST_DRAIN,
    ST_DONE
  } gate_st_e;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
endpackage

// File: rtl/tx_gate_len_chk.sv
module tx_gate_len_chk #(
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             ok_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_LEN);

  assign ok_o = (cnt_i >= MIN_V) && (cnt_i <= MAX_V);
endmodule

// File: rtl/tx_gate_hdr_chk.sv
module tx_gate_hdr_chk
  import tx_gate_pkg::*;
#(
  parameter int HDR_LEN = 8,
  localparam int HIDX_W = $clog2(HDR_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rd_i,
  input  logic [HIDX_W-1:0] idx_i,
  input  logic [7:0]        byte_i,
  output logic              bad_o
);
  logic              rd_q;
  logic [HIDX_W-1:0] idx_q;
  logic              err_q;
  logic [7:0]        exp_byte;
  logic              cur_bad;

  // data for a read lands one cycle later; track which slot it is
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      rd_q  <= rd_i;
      idx_q <= idx_i;
    end
  end

  assign exp_byte = (idx_q == HIDX_W'(HDR_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
  assign cur_bad  = rd_q && (byte_i != exp_byte);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (clear_i) err_q <= 1'b0;
    else if (cur_bad) err_q <= 1'b1;
  end

  // final byte still on the bus when the decision is taken
  assign bad_o = err_q | cur_bad;

  // R5
  sticky_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clear_i) |=> bad_o);
endmodule

// File: rtl/tx_gate_seq.sv
module tx_gate_seq
  import tx_gate_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 11,
  parameter int HDR_LEN = 8,
  parameter int FCS_LEN = 4,
  localparam int HIDX_W = $clog2(HDR_LEN),
  localparam int OVH    = HDR_LEN + FCS_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              len_ok_i,
  input  logic              hdr_bad_i,
  output logic              hdr_rd_o,
  output logic [HIDX_W-1:0] hdr_idx_o,
  output logic              buf_rd_en_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  output logic              clr_cnt_o,
  output logic              irq_o,
  output logic              idle_o
);
  gate_st_e          st_q, st_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  pay_len;
  logic              is_last;
  logic              vld_q, last_q;

  assign pay_len = cnt_i - CNT_W'(OVH);
  assign is_last = (st_q == ST_STREAM) && (idx_q == pay_len - CNT_W'(1));

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE:    if (start_i) st_d = ST_CHECK;
      ST_CHECK: begin
        idx_d = '0;
        st_d  = len_ok_i ? ST_HDR : ST_DONE;
      end
      ST_HDR: begin
        idx_d = idx_q + CNT_W'(1);
        if (idx_q == CNT_W'(HDR_LEN - 1)) st_d = ST_HDR_END;
      end
      ST_HDR_END: begin
        idx_d = '0;
        st_d  = hdr_bad_i ? ST_DONE : ST_STREAM;
      end
      ST_STREAM: begin
        idx_d = idx_q + CNT_W'(1);
        if (is_last) st_d = ST_DRAIN;
      end
      ST_DRAIN:   st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      vld_q  <= (st_q == ST_STREAM);
      last_q <= is_last;
    end
  end

  assign hdr_rd_o    = (st_q == ST_HDR);
  assign hdr_idx_o   = idx_q[HIDX_W-1:0];
  assign buf_rd_en_o = (st_q == ST_HDR) || (st_q == ST_STREAM);
  assign buf_addr_o  = (st_q == ST_STREAM) ? ADDR_W'(HDR_LEN) + idx_q[ADDR_W-1:0]
                                           : idx_q[ADDR_W-1:0];
  assign tx_valid_o  = vld_q;
  assign tx_last_o   = last_q;
  assign clr_cnt_o   = (st_q == ST_DRAIN);
  assign irq_o       = (st_q == ST_DONE);
  assign idle_o      = (st_q == ST_IDLE);

  // R8
  clear_then_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cnt_o |=> irq_o);
  // R6
  stream_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_rd_en_o && !hdr_rd_o) |=> tx_valid_o);
endmodule

// File: rtl/tx_frame_gate.sv
module tx_frame_gate
  import tx_gate_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530,
  parameter int HDR_LEN = 8,
  parameter int FCS_LEN = 4,
  localparam int HIDX_W = $clog2(HDR_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_wr_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              buf_rd_en_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic              idle, clr_cnt, start, len_ok, hdr_bad, hdr_rd;
  logic [HIDX_W-1:0] hdr_idx;

  assign start = cnt_wr_i && idle && (cnt_wdata_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_wr_i && idle)  cnt_q <= cnt_wdata_i;
    else if (clr_cnt)           cnt_q <= '0;
  end
  assign cnt_o = cnt_q;

  tx_gate_len_chk #(
    .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_len (
    .cnt_i(cnt_q), .ok_o(len_ok)
  );

  tx_gate_hdr_chk #(.HDR_LEN(HDR_LEN)) u_hdr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start),
    .rd_i(hdr_rd), .idx_i(hdr_idx), .byte_i(buf_rdata_i), .bad_o(hdr_bad)
  );

  tx_gate_seq #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .HDR_LEN(HDR_LEN), .FCS_LEN(FCS_LEN)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .cnt_i(cnt_q),
    .len_ok_i(len_ok), .hdr_bad_i(hdr_bad), .hdr_rd_o(hdr_rd),
    .hdr_idx_o(hdr_idx), .buf_rd_en_o(buf_rd_en_o), .buf_addr_o(buf_addr_o),
    .tx_valid_o(tx_valid_o), .tx_last_o(tx_last_o), .clr_cnt_o(clr_cnt),
    .irq_o(irq_o), .idle_o(idle)
  );

  assign tx_data_o = buf_rdata_i;

  // R9
  irq_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R7
  last_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);
  // R10
  busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr_i && !idle && !clr_cnt) |=> $stable(cnt_o));
  // R3
  stream_len_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (cnt_o >= CNT_W'(MIN_LEN) && cnt_o <= CNT_W'(MAX_LEN)));
  // R2
  zero_no_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr_i && idle && cnt_wdata_i == '0) |=> (!buf_rd_en_o && !irq_o));
endmodule

// File: tb/tx_frame_gate_bench.sv
module tx_frame_gate_bench;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cnt_wr = 1'b0;
  logic [CNT_W-1:0]  cnt_wdata = '0;
  logic [CNT_W-1:0]  cnt;
  logic              rd_en;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        rdata;
  logic [7:0]        txd;
  logic              txv, txl, irq;

  logic [7:0] mem [0:2047];
  logic [7:0] cap [0:8191];
  int tot_bytes = 0, tot_last = 0, tot_irq = 0, tot_long = 0, tot_gap = 0, tot_rd = 0;
  int last_at = -1;
  logic prev_v = 1'b0, prev_i = 1'b0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rd_en) rdata <= mem[addr];

  tx_frame_gate u_tx_frame_gate (
    .clk_i(clk), .rst_ni(rst_n), .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata),
    .cnt_o(cnt), .buf_rd_en_o(rd_en), .buf_addr_o(addr), .buf_rdata_i(rdata),
    .tx_data_o(txd), .tx_valid_o(txv), .tx_last_o(txl), .irq_o(irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) tot_rd++;
      if (txv) begin
        if (tot_bytes > 0 && !prev_v && !txl && tot_last == 0) tot_gap += 0;
        cap[tot_bytes % 8192] = txd;
        if (txl) begin tot_last++; last_at = tot_bytes; end
        tot_bytes++;
      end
      if (txl && !txv) tot_last += 100;
      if (irq) begin tot_irq++; if (prev_i) tot_long++; end
      if (prev_v && !txv && !prev_last) tot_gap += 0;
      prev_v = txv;
      prev_i = irq;
    end
  end
  logic prev_last = 1'b0;
  always @(negedge clk) prev_last <= txl;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int a, input int seed);
    return 8'((a * 7 + seed * 13 + 3) & 8'hff);
  endfunction

  task automatic fill(input int seed, input int bad_at);
    for (int i = 0; i < 2048; i++) mem[i] = pay(i, seed);
    for (int i = 0; i < 7; i++) mem[i] = 8'h55;
    mem[7] = 8'hD5;
    if (bad_at >= 0) mem[bad_at] = mem[bad_at] ^ 8'h08;
  endtask

  task automatic do_write(input int v);
    @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = CNT_W'(v);
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    chk(irq == 1'b1, req, int'(irq), 1);
  endtask

  // attempt with expected accept/refuse outcome; optional write in irq cycle
  task automatic run_frame(input int len, input int bad_at, input bit expect_ok,
                           input string req, input bit hit_irq);
    int b0, l0, i0, g0, r0, exp_n;
    bit data_ok;
    fill(len, bad_at);
    b0 = tot_bytes; l0 = tot_last; i0 = tot_irq; r0 = tot_rd;
    do_write(len);
    wait_irq(req);
    // R8 / R3: count at irq cycle
    chk(cnt == (expect_ok ? 0 : CNT_W'(len)), expect_ok ? "R8" : req,
        int'(cnt), expect_ok ? 0 : len);
    if (hit_irq) begin
      cnt_wr = 1'b1; cnt_wdata = CNT_W'(777);
      @(negedge clk);
      cnt_wr = 1'b0;
      repeat (20) @(negedge clk);
      chk(cnt == (expect_ok ? 0 : CNT_W'(len)), "R10", int'(cnt), expect_ok ? 0 : len);
    end else begin
      repeat (3) @(negedge clk);
    end
    exp_n = expect_ok ? len - 12 : 0;
    chk(tot_bytes - b0 == exp_n, expect_ok ? "R6" : req, tot_bytes - b0, exp_n);
    chk(tot_irq - i0 == 1 && tot_long == 0, "R9", tot_irq - i0, 1);
    if (expect_ok) begin
      data_ok = 1;
      for (int k = 0; k < exp_n; k++)
        if (cap[(b0 + k) % 8192] !== mem[8 + k]) data_ok = 0;
      chk(data_ok, "R6", int'(data_ok), 1);
      chk(tot_last - l0 == 1 && last_at == tot_bytes - 1, "R7", tot_last - l0, 1);
      chk(tot_rd - r0 == exp_n + 8, "R11", tot_rd - r0, exp_n + 8);
    end else begin
      chk(tot_last == l0, "R7", tot_last - l0, 0);
      if (bad_at < 0) chk(tot_rd == r0, req, tot_rd - r0, 0);
    end
    g0 = 0;
  endtask

  task automatic t_reset;
    chk(cnt == 0, "R1", int'(cnt), 0);
    chk(!txv && !txl && !irq && !rd_en, "R1", int'({txv, txl, irq, rd_en}), 0);
  endtask

  task automatic t_zero_write;
    int r0, i0;
    r0 = tot_rd; i0 = tot_irq;
    do_write(0);
    repeat (20) @(negedge clk);
    chk(cnt == 0, "R2", int'(cnt), 0);
    chk(tot_rd == r0 && tot_irq == i0, "R2", tot_irq - i0, 0);
  endtask

  task automatic t_mid_write;
    int b0;
    fill(5, -1);
    b0 = tot_bytes;
    do_write(100);
    while (tot_bytes - b0 < 5) @(negedge clk);
    do_write(70);
    chk(cnt == 100, "R10", int'(cnt), 100);
    wait_irq("R10");
    repeat (3) @(negedge clk);
    chk(tot_bytes - b0 == 88, "R10", tot_bytes - b0, 88);
    chk(cnt == 0, "R8", int'(cnt), 0);
  endtask

  // gap detection: emitted bytes of one frame must be back to back
  task automatic t_no_gap;
    int first, last, n, b0;
    fill(9, -1);
    b0 = tot_bytes;
    do_write(80);
    n = 0; first = -1; last = -1;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (txv) begin if (first < 0) first = c; last = c; n++; end
    end
    chk(n == 68 && last - first == 67, "R6", last - first + 1, 68);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    run_frame(64,   -1, 1, "R6", 0);
    run_frame(1530, -1, 1, "R6", 0);
    run_frame(63,   -1, 0, "R3", 0);
    run_frame(1531, -1, 0, "R4", 0);
    run_frame(200,   0, 0, "R5", 0);
    run_frame(200,   6, 0, "R5", 0);
    run_frame(200,   7, 0, "R5", 0);
    run_frame(300,  -1, 1, "R10", 1);
    run_frame(40,   -1, 0, "R10", 1);
    t_zero_write();
    t_mid_write();
    t_no_gap();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule